// File: doc/BRIEF.md
# Atomic-Lock Memory Access Arbiter

This block decides, cycle by cycle, which of several CPU initiators may access a single shared memory controller. Every CPU presents a write request, a read request, two qualifiers that mark each of those requests as part of an atomic sequence, and a halt input. The arbiter answers with at most one grant per cycle. Grants are combinational from the current requests and the internal state, and a request is taken in the cycle its grant is high.

When an atomic access is granted, the arbiter becomes a sticky lock owned by that CPU. Only the owner is served until both of its qualifiers fall or it halts. Unlocked traffic is shared round-robin. When a lock ends, one pending non-atomic access is served before any atomic requester can take the next lock. Successive atomic owners therefore rotate around the ring with plain traffic interleaved between them. A saturating counter watches the number of atomic grants in one continuous lock and raises an error once it goes past the sequence limit.

Top module: `atomic_lock_arb`

## Requirements
- R1: After a synchronous active-low reset, `lock_active`, `lock_owner`, `seq_overflow` and all grants are 0. The round-robin search starts at CPU0.
- R2: At most one bit of `{gnt_wr, gnt_rd}` is high in any cycle. A grant goes only to a matching request, and never to a CPU whose `halt` bit is high.
- R3: Within one CPU, a write request is granted before a read request.
- R4: While no lock is in force, the search for the next grant starts at the CPU after the last one granted and wraps from the highest index to CPU0.
- R5: A granted access whose qualifier (`atom_wr` for a write, `atom_rd` for a read) is high makes `lock_active` 1 on the next cycle, with `lock_owner` equal to that CPU's index.
- R6: While the lock is in force (`lock_active` is 1, at least one owner qualifier is high, and the owner is not halted), only the owner can be granted. This holds for atomic and plain requests alike.
- R7: As long as either owner qualifier stays high, the lock and the owner are unchanged. This holds across back-to-back atomic sequences.
- R8: In the cycle when both owner qualifiers are low, other CPUs can already be granted, and `lock_active` is 0 on the next cycle unless a new atomic grant occurs.
- R9: A high `halt` on the owner drops the lock in that same cycle, in the same way as R8.
- R10: In the cycle a lock ends, if any non-halted CPU has a plain (non-atomic) request, only plain requests compete. Exactly one plain access is served before the next lock can be taken.
- R11: Atomic requesters take the lock in ring order starting after the previous owner.
- R12: The counter is set to 1 when a lock is taken and increments on each further atomic grant while the lock continues. `seq_overflow` is 1 while the count exceeds `MAX_PKTS` (default 256), and it returns to 0 on the cycle after the lock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | N_CPU | Write request per CPU |
| rd_req | input | N_CPU | Read request per CPU |
| atom_wr | input | N_CPU | Marks the write request (and the sequence) as atomic |
| atom_rd | input | N_CPU | Marks the read request (and the sequence) as atomic |
| halt | input | N_CPU | CPU halted: masks its requests and drops its lock |
| gnt_wr | output | N_CPU | Write grant, at most one grant bit overall |
| gnt_rd | output | N_CPU | Read grant |
| lock_active | output | 1 | A CPU currently holds the lock |
| lock_owner | output | $clog2(N_CPU) | Index of the lock holder |
| seq_overflow | output | 1 | Atomic grants in the current lock exceeded MAX_PKTS |

## Verification
The hardest situation to reach is the hand-off cycle. In that cycle the owner's qualifiers have just dropped, or its halt has just risen, while a plain request and an atomic request from two other CPUs wait at the same time, and the round-robin pointer favours the atomic one. The directed sequence builds this on purpose: it parks an atomic request on the CPU right after the owner and a plain request on the CPU after that, then releases the lock. It repeats the setup with halt as the release cause. The overflow edge is reached by holding one owner's atomic write request high for 257 consecutive grants. A sweep then covers every plain request and halt combination from each pointer position.

// File: rtl/atomic_lock_arb_pkg.sv
package atomic_lock_arb_pkg;

  // Per-CPU classification of the pending requests
  typedef struct packed {
    logic wr_na;   // plain write
    logic rd_na;   // plain read
    logic wr_at;   // atomic write
    logic rd_at;   // atomic read
  } cpu_req_t;

  function automatic cpu_req_t classify(input logic wr, input logic rd,
                                        input logic awr, input logic ard,
                                        input logic hlt);
    cpu_req_t r;
    r.wr_na = wr & ~awr & ~hlt;
    r.rd_na = rd & ~ard & ~hlt;
    r.wr_at = wr &  awr & ~hlt;
    r.rd_at = rd &  ard & ~hlt;
    return r;
  endfunction

endpackage

// File: rtl/arb_ring_pick.sv
module arb_ring_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int off = 0; off < N; off++) begin
      int c;
      c = int'(start) + off;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
    onehot = found ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
  end

endmodule

// File: rtl/arb_lock_ctrl.sv
module arb_lock_ctrl #(
  parameter int IW       = 2,
  parameter int MAX_PKTS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  input  logic          inc,
  input  logic          release_now,
  output logic          lock_q,
  output logic [IW-1:0] owner_q,
  output logic          overflow
);

  localparam int CW = $clog2(MAX_PKTS + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(MAX_PKTS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      cnt_q   <= '0;
    end else if (take) begin
      lock_q  <= 1'b1;
      owner_q <= take_idx;
      cnt_q   <= CW'(1);
    end else if (release_now) begin
      lock_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (inc && cnt_q != CNT_SAT) begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign overflow = (cnt_q > CW'(MAX_PKTS));

endmodule

// File: rtl/atomic_lock_arb.sv
module atomic_lock_arb
  import atomic_lock_arb_pkg::*;
#(
  parameter int N_CPU    = 3,
  parameter int MAX_PKTS = 256,
  localparam int IW      = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CPU-1:0] wr_req,
  input  logic [N_CPU-1:0] rd_req,
  input  logic [N_CPU-1:0] atom_wr,
  input  logic [N_CPU-1:0] atom_rd,
  input  logic [N_CPU-1:0] halt,
  output logic [N_CPU-1:0] gnt_wr,
  output logic [N_CPU-1:0] gnt_rd,
  output logic             lock_active,
  output logic [IW-1:0]    lock_owner,
  output logic             seq_overflow
);

  cpu_req_t [N_CPU-1:0] cls;
  logic [N_CPU-1:0] na_any, at_any, cand, sel_wr, own_oh;
  logic [N_CPU-1:0] win_oh;
  logic [IW-1:0]    win_idx, rr_q;
  logic             win_found;
  logic             lock_q, locked_eff, release_now, gap_mode;
  logic [IW-1:0]    owner_q;
  logic             atom_grant, take, inc, any_grant;

  // Per-CPU request classification
  for (genvar i = 0; i < N_CPU; i++) begin : g_cls
    assign cls[i]    = classify(wr_req[i], rd_req[i], atom_wr[i], atom_rd[i], halt[i]);
    assign na_any[i] = cls[i].wr_na | cls[i].rd_na;
    assign at_any[i] = cls[i].wr_at | cls[i].rd_at;
    assign cand[i]   = gap_mode ? na_any[i] : (na_any[i] | at_any[i]);
    assign sel_wr[i] = gap_mode ? cls[i].wr_na : (cls[i].wr_na | cls[i].wr_at);
    assign own_oh[i] = (owner_q == IW'(i));
  end

  // Lock is only in force while an owner qualifier is up and it is not halted
  assign locked_eff  = lock_q & (atom_wr[owner_q] | atom_rd[owner_q]) & ~halt[owner_q];
  assign release_now = lock_q & ~locked_eff;
  assign gap_mode    = release_now & (|na_any);

  arb_ring_pick #(.N(N_CPU), .IW(IW)) pick_i (
    .req    (cand),
    .start  (rr_q),
    .found  (win_found),
    .idx    (win_idx),
    .onehot (win_oh)
  );

  always_comb begin
    if (locked_eff) begin
      // Owner only; write before read
      gnt_wr = own_oh & wr_req;
      gnt_rd = (|(own_oh & wr_req)) ? '0 : (own_oh & rd_req);
    end else begin
      gnt_wr = win_oh & sel_wr;
      gnt_rd = win_oh & ~sel_wr;
    end
  end

  assign atom_grant = |((gnt_wr & atom_wr) | (gnt_rd & atom_rd));
  assign any_grant  = |(gnt_wr | gnt_rd);
  assign take       = ~locked_eff & atom_grant;
  assign inc        = locked_eff & atom_grant;

  // Round-robin pointer moves past each unlocked winner
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (!locked_eff && any_grant && win_found) begin
      rr_q <= (win_idx == IW'(N_CPU - 1)) ? '0 : win_idx + IW'(1);
    end
  end

  arb_lock_ctrl #(.IW(IW), .MAX_PKTS(MAX_PKTS)) lock_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .take_idx    (win_idx),
    .inc         (inc),
    .release_now (release_now),
    .lock_q      (lock_q),
    .owner_q     (owner_q),
    .overflow    (seq_overflow)
  );

  assign lock_active = lock_q;
  assign lock_owner  = owner_q;

endmodule

// File: rtl/atomic_lock_arb_chk.sv
module atomic_lock_arb_chk #(
  parameter int N_CPU    = 3,
  parameter int MAX_PKTS = 256,
  localparam int IW      = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CPU-1:0] wr_req,
  input logic [N_CPU-1:0] rd_req,
  input logic [N_CPU-1:0] atom_wr,
  input logic [N_CPU-1:0] atom_rd,
  input logic [N_CPU-1:0] halt,
  input logic [N_CPU-1:0] gnt_wr,
  input logic [N_CPU-1:0] gnt_rd,
  input logic             lock_active,
  input logic [IW-1:0]    lock_owner,
  input logic             seq_overflow
);

  logic own_q, own_h, at_g;
  logic [N_CPU-1:0] own_mask;
  always_comb begin
    own_q    = atom_wr[lock_owner] | atom_rd[lock_owner];
    own_h    = halt[lock_owner];
    at_g     = |((gnt_wr & atom_wr) | (gnt_rd & atom_rd));
    own_mask = {{(N_CPU-1){1'b0}}, 1'b1} << lock_owner;
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_wr, gnt_rd}));
  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_wr & ~wr_req) | (gnt_rd & ~rd_req) | ((gnt_wr | gnt_rd) & halt)) == '0);
  // R6
  owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && own_q && !own_h) |-> (((gnt_wr | gnt_rd) & ~own_mask) == '0));
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && own_q && !own_h) |=> (lock_active && lock_owner == $past(lock_owner)));
  // R8
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && !own_q && !at_g) |=> !lock_active);
  // R9
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && own_h && !at_g) |=> !lock_active);
  // R12
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |-> !seq_overflow);

  for (genvar i = 0; i < N_CPU; i++) begin : g_take
    // R5
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_wr[i] && atom_wr[i]) || (gnt_rd[i] && atom_rd[i]))
        |=> (lock_active && lock_owner == IW'(i)));
  end

endmodule

bind atomic_lock_arb atomic_lock_arb_chk #(.N_CPU(N_CPU), .MAX_PKTS(MAX_PKTS)) chk_i (.*);

// File: tb/atomic_lock_arb_tb_top.sv
module atomic_lock_arb_tb_top;

  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] wr_req = '0, rd_req = '0, atom_wr = '0, atom_rd = '0, halt = '0;
  logic [N-1:0] gnt_wr, gnt_rd;
  logic         lock_active, seq_overflow;
  logic [1:0]   lock_owner;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  atomic_lock_arb #(.N_CPU(N), .MAX_PKTS(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .atom_wr(atom_wr), .atom_rd(atom_rd), .halt(halt),
    .gnt_wr(gnt_wr), .gnt_rd(gnt_rd), .lock_active(lock_active),
    .lock_owner(lock_owner), .seq_overflow(seq_overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic clr();
    wr_req = '0; rd_req = '0; atom_wr = '0; atom_rd = '0; halt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) adv();
    #1;
    chk("R1 lock", lock_active, 0);
    chk("R1 owner", lock_owner, 0);
    chk("R1 ovf", seq_overflow, 0);
    chk("R1 grants", {gnt_wr, gnt_rd}, 0);
    adv();
    rst_n = 1'b1;
    adv();
    rd_req = 3'b111; #1;
    chk("R1 rr start", gnt_rd, 3'b001);
    clr(); adv();
    // rr now at 1; walk to 0 again
    wr_req = 3'b100; #1; adv(); clr();

    // R5: CPU0 atomic write takes lock
    wr_req[0] = 1; atom_wr[0] = 1; #1;
    chk("R5 grant", gnt_wr, 3'b001);
    adv(); wr_req[0] = 0; #1;
    chk("R5 lock", lock_active, 1);
    chk("R5 owner", lock_owner, 0);
    // R6: others blocked
    wr_req[1] = 1; atom_wr[1] = 1; rd_req[2] = 1; #1;
    chk("R6 blocked", {gnt_wr, gnt_rd}, 0);
    rd_req[0] = 1; atom_rd[0] = 1; #1;
    chk("R6 owner read", {gnt_wr, gnt_rd}, 6'b000001);
    adv(); rd_req[0] = 0;
    // R7: swap qualifiers without both low
    atom_wr[0] = 0; #1;
    chk("R7 no grant", {gnt_wr, gnt_rd}, 0);
    adv(); #1;
    chk("R7 lock kept", lock_active, 1);
    chk("R7 owner kept", lock_owner, 0);
    // R8/R10: release; CPU1 atomic (rr favours it), CPU2 plain
    atom_rd[0] = 0; #1;
    chk("R10 plain first", {gnt_wr, gnt_rd}, 6'b000100);
    adv(); rd_req[2] = 0; #1;
    chk("R8 lock dropped", lock_active, 0);
    chk("R11 next atomic", gnt_wr, 3'b010);
    adv(); wr_req[1] = 0; #1;
    chk("R11 owner1", lock_owner, 1);
    chk("R11 lock1", lock_active, 1);
    // R11 rotation: CPU0 and CPU2 atomic waiting
    wr_req[0] = 1; atom_wr[0] = 1; wr_req[2] = 1; atom_wr[2] = 1; #1;
    chk("R6 wait", {gnt_wr, gnt_rd}, 0);
    atom_wr[1] = 0; #1;
    chk("R11 ring order", gnt_wr, 3'b100);
    adv(); wr_req[2] = 0; #1;
    chk("R11 owner2", lock_owner, 2);
    // R9: halt owner with plain read from CPU1 pending
    rd_req[1] = 1; halt[2] = 1; wr_req[2] = 1; #1;
    chk("R9 halt release", {gnt_wr, gnt_rd}, 6'b000010);
    adv(); rd_req[1] = 0; #1;
    chk("R9 lock dropped", lock_active, 0);
    chk("R9 halted skipped", gnt_wr, 3'b001);
    adv(); halt = '0; wr_req[2] = 0; atom_wr[2] = 0; #1;
    chk("R5 owner0", lock_owner, 0);
    // R12: CPU0 keeps issuing atomic writes; count is 1 now
    repeat (255) adv();
    #1; chk("R12 at limit", seq_overflow, 0);
    adv(); #1;
    chk("R12 over limit", seq_overflow, 1);
    clr(); adv(); #1;
    chk("R12 cleared", seq_overflow, 0);
    chk("R8 lock off", lock_active, 0);

    // Sweep: plain requests, halts, each pointer position (R2 R3 R4)
    for (int p = 0; p < N; p++) begin
      for (int pat = 0; pat < 64; pat++) begin
        for (int h = 0; h < 8; h++) begin
          logic [N-1:0] ew, er;
          clr();
          wr_req[(p + N - 1) % N] = 1'b1; #1;
          adv();
          clr();
          wr_req = pat[2:0]; rd_req = pat[5:3]; halt = h[2:0];
          ew = '0; er = '0;
          for (int off = 0; off < N; off++) begin
            int c;
            c = (p + off) % N;
            if ((ew | er) == '0 && !halt[c]) begin
              if (wr_req[c]) ew[c] = 1'b1;
              else if (rd_req[c]) er[c] = 1'b1;
            end
          end
          #1;
          chk("R2 R3 R4 sweep", {gnt_wr, gnt_rd}, {ew, er});
          adv();
        end
      end
    end
    clr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule